// File: doc/BRIEF.md
# Bitfield Extract and Insert Engine

This engine moves variable-length bitfields between a 16-bit accumulator and a stream of little-endian 16-bit words in memory. A field is addressed by a byte pointer to a word and a 4-bit bit offset within that word. It is (length code + 1) bits long, so it holds 1 to 16 bits, and it may run on into the following word. In extract mode the field is read and returned zero-extended. In insert mode the low bits of the accumulator are merged into memory by read-modify-write, and every bit outside the field is kept.

After each operation the engine returns an advanced cursor. The new offset is the old offset plus the field length, modulo 16. The pointer moves on by one word (2 bytes) only when that sum reaches or passes 16. Feeding the returned cursor into the next request walks packed fields back to back across word boundaries.

The engine has a start/busy/done handshake. It drives a single-port memory that takes one access per cycle, with read data returned the cycle after the request.

Top module: `bitfield_walker`

## Requirements
- R1: Extract returns on `acc_out` bits [offset .. offset+len_code] of the 32-bit window {word at ptr+2, word at ptr}, placed at bit 0, with all higher bits zero.
- R2: Insert writes bit i of `acc_in` (for i from 0 to len_code) to window bit offset+i, and leaves every other bit of both words unchanged.
- R3: On completion `offset_out` equals (offset + len_code + 1) mod 16.
- R4: On completion `ptr_out` equals ptr + 2 when offset + len_code + 1 >= 16, and equals ptr otherwise.
- R5: A field with offset + len_code + 1 <= 16 touches only the word at ptr, with one memory access for extract and two for insert. A longer field also touches ptr+2, with two accesses for extract and four for insert. `mem_we` is never high without `mem_req`.
- R6: A `start` while idle raises `busy` in the next cycle. `done` is a single-cycle pulse that comes with `busy` low. A `start` while busy is ignored: it changes neither the result nor the number of completions.
- R7: Extract never writes memory. Insert returns `acc_in` unchanged on `acc_out`.
- R8: After reset `busy`, `done`, `mem_req` and `mem_we` are low, and `offset_out`, `ptr_out` and `acc_out` are zero.
- R9: A field that ends exactly on bit 15 advances the pointer by 2 and wraps the offset to the same value it started from when the length is 16, yet it accesses only the word at ptr.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| op_insert | input | 1 | 1 = insert, 0 = extract |
| off_in | input | 4 | Starting bit offset |
| len_code | input | 4 | Field length minus one |
| acc_in | input | 16 | Accumulator supplying insert data |
| ptr_in | input | AW | Byte pointer to the first word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse, results valid |
| offset_out | output | 4 | Advanced bit offset |
| ptr_out | output | AW | Advanced byte pointer |
| acc_out | output | 16 | Extracted field, or the unchanged accumulator on insert |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after a read request |

## Verification
The bench aims at the boundary between one and two words. Offset plus length of exactly 16 must advance the pointer without a second access, and a sum of 17 must fetch the next word. A design that compares with the wrong bound either reads a word it does not need or drops the upper bits of the field. Single-bit fields at bit 15 and full 16-bit fields at offset 15 test the mask width: an off-by-one mask corrupts a neighbouring bit on insert, or leaks a stray bit into the extract result. A chain of fields fed from the returned cursor, together with a start pulse issued mid-operation, shows whether the offset wraps correctly and whether a busy engine can be restarted or made to complete twice.

// File: rtl/bfw_pkg.sv
package bfw_pkg;
  localparam int W  = 16;
  localparam int OW = $clog2(W);
  localparam int W2 = 2 * W;

  typedef logic [W-1:0]  word_t;
  typedef logic [OW-1:0] idx_t;
  typedef logic [W2-1:0] win_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_LO, ST_GET_LO, ST_GET_HI, ST_WR_LO, ST_WR_HI, ST_FIN
  } st_t;

  // ones in the low (lc+1) positions
  function automatic word_t field_mask(idx_t lc);
    int   n;
    win_t m;
    n = int'(lc) + 1;
    m = (win_t'(1) << n) - win_t'(1);
    return m[W-1:0];
  endfunction

  function automatic word_t pull_field(win_t win, idx_t off, idx_t lc);
    win_t s;
    s = win >> off;
    return s[W-1:0] & field_mask(lc);
  endfunction

  function automatic win_t blend(win_t win, idx_t off, idx_t lc, word_t acc);
    win_t m;
    win_t d;
    m = win_t'(field_mask(lc)) << off;
    d = win_t'(acc & field_mask(lc)) << off;
    return (win & ~m) | d;
  endfunction
endpackage

// File: rtl/bfw_cursor.sv
module bfw_cursor
  import bfw_pkg::*;
#(
  parameter int AW = 16
) (
  input  idx_t          off,
  input  idx_t          lc,
  input  logic [AW-1:0] ptr,
  output idx_t          off_next,
  output logic [AW-1:0] ptr_next,
  output logic          wrap,
  output logic          span
);
  logic [OW:0] sum;

  always_comb begin
    sum      = {1'b0, off} + {1'b0, lc} + (OW+1)'(1);
    off_next = sum[OW-1:0];
    wrap     = sum[OW];
    span     = sum[OW] && (sum[OW-1:0] != '0);
    ptr_next = wrap ? ptr + AW'(2) : ptr;
  end
endmodule

// File: rtl/bfw_field.sv
module bfw_field
  import bfw_pkg::*;
(
  input  word_t lo,
  input  word_t hi,
  input  idx_t  off,
  input  idx_t  lc,
  input  word_t acc,
  output word_t xval,
  output word_t new_lo,
  output word_t new_hi
);
  win_t merged;

  always_comb begin
    xval   = pull_field({hi, lo}, off, lc);
    merged = blend({hi, lo}, off, lc, acc);
    new_lo = merged[W-1:0];
    new_hi = merged[W2-1:W];
  end
endmodule

// File: rtl/bitfield_walker.sv
module bitfield_walker
  import bfw_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_insert,
  input  logic [3:0]    off_in,
  input  logic [3:0]    len_code,
  input  logic [15:0]   acc_in,
  input  logic [AW-1:0] ptr_in,
  output logic          busy,
  output logic          done,
  output logic [3:0]    offset_out,
  output logic [AW-1:0] ptr_out,
  output logic [15:0]   acc_out,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata
);
  st_t           st, st_nx;
  logic          op_q;
  idx_t          off_q, lc_q;
  word_t         acc_q, lo_q, hi_q;
  logic [AW-1:0] ptr_q, ptr_hi;
  idx_t          off_next;
  logic [AW-1:0] ptr_next;
  logic          wrap, span;
  word_t         xval, new_lo, new_hi;

  bfw_cursor #(.AW(AW)) u_cursor (
    .off(off_q), .lc(lc_q), .ptr(ptr_q),
    .off_next(off_next), .ptr_next(ptr_next), .wrap(wrap), .span(span)
  );

  bfw_field u_field (
    .lo(lo_q), .hi(hi_q), .off(off_q), .lc(lc_q), .acc(acc_q),
    .xval(xval), .new_lo(new_lo), .new_hi(new_hi)
  );

  assign ptr_hi = ptr_q + AW'(2);
  assign busy   = (st != ST_IDLE);

  always_comb begin
    mem_req   = (st == ST_RD_LO) || (st == ST_GET_LO && span) ||
                (st == ST_WR_LO) || (st == ST_WR_HI);
    mem_we    = (st == ST_WR_LO) || (st == ST_WR_HI);
    mem_addr  = (st == ST_GET_LO || st == ST_WR_HI) ? ptr_hi : ptr_q;
    mem_wdata = (st == ST_WR_HI) ? new_hi : new_lo;
  end

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:   if (start) st_nx = ST_RD_LO;
      ST_RD_LO:  st_nx = ST_GET_LO;
      ST_GET_LO: st_nx = span ? ST_GET_HI : (op_q ? ST_WR_LO : ST_FIN);
      ST_GET_HI: st_nx = op_q ? ST_WR_LO : ST_FIN;
      ST_WR_LO:  st_nx = span ? ST_WR_HI : ST_FIN;
      ST_WR_HI:  st_nx = ST_FIN;
      ST_FIN:    st_nx = ST_IDLE;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      op_q       <= 1'b0;
      off_q      <= '0;
      lc_q       <= '0;
      acc_q      <= '0;
      ptr_q      <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
      done       <= 1'b0;
      offset_out <= '0;
      ptr_out    <= '0;
      acc_out    <= '0;
    end else begin
      st   <= st_nx;
      done <= (st == ST_FIN);
      if (st == ST_IDLE && start) begin
        op_q  <= op_insert;
        off_q <= off_in;
        lc_q  <= len_code;
        acc_q <= acc_in;
        ptr_q <= ptr_in;
        hi_q  <= '0;
      end
      if (st == ST_GET_LO) lo_q <= mem_rdata;
      if (st == ST_GET_HI) hi_q <= mem_rdata;
      if (st == ST_FIN) begin
        offset_out <= off_next;
        ptr_out    <= ptr_next;
        acc_out    <= op_q ? acc_q : xval;
      end
    end
  end

  // completion is a lone pulse, seen only once the engine is idle again
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // a write is always a real access, and only an insert writes
  p_we_has_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);
  p_extract_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_q) |-> !mem_we);
  p_insert_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q) |-> (acc_out == acc_q));
  // pointer moves exactly when the offset did not grow
  p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((ptr_out != ptr_q) == (offset_out <= off_q)));
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((ptr_out == ptr_q) || (ptr_out == ptr_q + AW'(2))));
endmodule

// File: tb/bitfield_walker_test.sv
module bitfield_walker_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          op_insert = 1'b0;
  logic [3:0]    off_in = '0;
  logic [3:0]    len_code = '0;
  logic [15:0]   acc_in = '0;
  logic [AW-1:0] ptr_in = '0;
  logic          busy, done, mem_req, mem_we;
  logic [3:0]    offset_out;
  logic [AW-1:0] ptr_out, mem_addr;
  logic [15:0]   acc_out, mem_wdata;
  logic [15:0]   mem_rdata = '0;

  logic [15:0] mem [0:63];
  int n_checks = 0;
  int n_fail = 0;
  int acc_cnt = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    logic        ins;
    logic [15:0] acc;
    logic [3:0]  off;
    logic [15:0] ptr;
    int          accesses;
    int          base;
    int          widx;
    logic [15:0] w0;
    logic [15:0] w1;
  } item_t;
  item_t sb[$];

  bitfield_walker #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_insert(op_insert),
    .off_in(off_in), .len_code(len_code), .acc_in(acc_in), .ptr_in(ptr_in),
    .busy(busy), .done(done), .offset_out(offset_out), .ptr_out(ptr_out),
    .acc_out(acc_out), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[6:1]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[6:1]];
    end
    if (rst_n && mem_req) acc_cnt <= acc_cnt + 1;
    cyc <= cyc + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk("R6 unexpected completion", 32'd1, 32'd0);
      end else begin
        item_t it;
        it = sb.pop_front();
        chk(it.ins ? "R7 insert keeps accumulator" : "R1 extracted field",
            32'(acc_out), 32'(it.acc));
        chk("R3 offset advance", 32'(offset_out), 32'(it.off));
        chk("R4 pointer advance", 32'(ptr_out), 32'(it.ptr));
        chk(it.ins ? "R2 low word merge" : "R7 extract leaves low word",
            32'(mem[it.widx]), 32'(it.w0));
        chk(it.ins ? "R2 high word merge" : "R7 extract leaves high word",
            32'(mem[it.widx+1]), 32'(it.w1));
        chk("R5 access count", 32'(acc_cnt - it.base), 32'(it.accesses));
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  logic [3:0]  cur_off;
  logic [15:0] cur_ptr;

  task automatic do_op(input logic ins, input logic [3:0] off, input logic [3:0] lc,
                       input logic [15:0] acc, input logic [15:0] ptr, input bit poke);
    item_t it;
    logic [15:0] w [2];
    logic [15:0] fld;
    int n, sum;
    n = int'(lc) + 1;
    it.widx = int'(ptr[6:1]);
    w[0] = mem[it.widx];
    w[1] = mem[it.widx+1];
    fld = '0;
    for (int i = 0; i < n; i++) begin
      int p;
      p = int'(off) + i;
      if (ins) w[p/16][p%16] = acc[i];
      else     fld[i] = w[p/16][p%16];
    end
    sum = int'(off) + n;
    it.ins = ins;
    it.acc = ins ? acc : fld;
    it.off = 4'(sum % 16);
    it.ptr = (sum >= 16) ? ptr + 16'd2 : ptr;
    it.accesses = ((sum > 16) ? 2 : 1) * (ins ? 2 : 1);
    it.w0 = w[0];
    it.w1 = w[1];
    cur_off = it.off;
    cur_ptr = it.ptr;
    @(negedge clk);
    it.base = acc_cnt;
    sb.push_back(it);
    op_insert = ins; off_in = off; len_code = lc; acc_in = acc; ptr_in = ptr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R6 busy after start", 32'(busy), 32'd1);
    if (poke) begin
      // R6: a second request while busy must be ignored
      op_insert = ~ins; off_in = ~off; len_code = ~lc; acc_in = ~acc; ptr_in = ptr + 16'd4;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 64; i++) mem[i] = 16'hA5C3 ^ 16'(i * 16'h1357);
    repeat (3) @(negedge clk);
    // R8 reset values
    chk("R8 busy", 32'(busy), 32'd0);
    chk("R8 done", 32'(done), 32'd0);
    chk("R8 mem_req", 32'({mem_req, mem_we}), 32'd0);
    chk("R8 results", 32'({offset_out, ptr_out, acc_out}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    do_op(1'b0, 4'd0,  4'd15, 16'h0000, 16'h0010, 0); // R9 full word
    do_op(1'b0, 4'd4,  4'd3,  16'h0000, 16'h0012, 0);
    do_op(1'b0, 4'd12, 4'd7,  16'h0000, 16'h0014, 0); // spans
    do_op(1'b1, 4'd5,  4'd5,  16'hFFFF, 16'h0020, 0);
    do_op(1'b1, 4'd10, 4'd11, 16'h0ABC, 16'h0024, 0); // spans
    do_op(1'b1, 4'd8,  4'd7,  16'h1200, 16'h0028, 0); // R9 ends on bit 15
    do_op(1'b0, 4'd15, 4'd0,  16'h0000, 16'h002A, 0); // single top bit
    do_op(1'b0, 4'd15, 4'd15, 16'h0000, 16'h002C, 0); // widest span
    do_op(1'b1, 4'd15, 4'd0,  16'h0000, 16'h0030, 0);
    do_op(1'b1, 4'd3,  4'd9,  16'h5A5A, 16'h0032, 1); // R6 poke while busy
    do_op(1'b0, 4'd9,  4'd9,  16'h0000, 16'h0034, 1);

    // walk packed 5-bit fields through the returned cursor
    cur_off = 4'd0; cur_ptr = 16'h0040;
    for (int k = 0; k < 8; k++) do_op(1'b1, cur_off, 4'd4, 16'(k * 7 + 3), cur_ptr, 0);
    cur_off = 4'd0; cur_ptr = 16'h0040;
    for (int k = 0; k < 8; k++) do_op(1'b0, cur_off, 4'd4, 16'h0000, cur_ptr, 0);

    lf = 16'hACE1;
    for (int k = 0; k < 40; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      do_op(lf[0], lf[4:1], lf[8:5], lf ^ 16'h5A5A, 16'({lf[14:10], 1'b0}), k[2]);
    end

    repeat (4) @(negedge clk);
    chk("R6 every request completed once", 32'(sb.size()), 32'd0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule